// File: doc/BRIEF.md
# Programmable-Timing External Memory Bus Controller

This block turns single read and write requests from an on-chip requester into accesses on a slow asynchronous external memory bus. The external bus has a 9-bit address, a 16-bit data path, active-low output-enable, write-enable and address-valid strobes, and six active-low chip selects. The data path is split into an output, an output enable and an input, so that the pad ring can build the bidirectional pins.

Each chip select has its own timing set. The set holds separate read and write strobe lengths, a write hold time, a data-bus recovery time, separate read and write latencies that are paid on the first access to a 4-word page, and a fast mode. In fast mode the access opens with an address-valid pulse and a programmable delay before the strobe. The controller decides which chip select a request targets and keeps address and write data stable while that select is low. It also inserts the programmed idle cycles, including the bus turnaround after reads.

The request side is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the requester must hold its fields steady until it sees ready. The read response is a one-cycle `rsp_valid` pulse and cannot be stalled. The timing registers are written through a plain register port and are not read back.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, all chip selects and strobes are high, `xb_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1. All timing fields reset to 0, so the first access after reset uses a one-cycle strobe, no latency and slow mode.
- R2: A read drives only the target select low (`xb_cs_n[i]` for chip select i), keeps `xb_we_n` high and `xb_dq_oe` low, and holds `xb_oe_n` low for read-wait+1 cycles.
- R3: A read returns `rsp_valid` high for exactly one cycle, the cycle right after the last cycle with `xb_oe_n` low. `rsp_rdata` is the value of `xb_dq_i` in that last cycle.
- R4: A write holds `xb_we_n` low for write-wait+1 cycles, keeps `xb_oe_n` high, and drives `xb_dq_oe` high with `xb_dq_o` equal to the request's write data.
- R5: After `xb_we_n` rises, the target select stays low for write-hold+1 more cycles. During these cycles `xb_dq_oe` stays high with the same data, and then the select goes high.
- R6: If the previous access was a read, and the new access targets a different chip select or is a write, then max(R,1) cycles with all selects high and `xb_dq_oe` low are inserted first. R is the recovery field of the chip select that was read. A read after a read to the same chip select, and any access after a write, get no recovery cycles.
- R7: The first access after reset is a page miss. So is an access whose chip select or address bits [8:2] differ from those of the previous access. A page miss adds read-latency or write-latency extra idle cycles, taken from the target chip select, after any recovery and before the select goes low. A page hit adds none.
- R8: In fast mode (mode field bit 0), `xb_adv_n` is low in exactly the first cycle with the select low. After that come A+G cycles with the select low and no strobe, where A is the address-hold bit (mode bit 1) and G is the gap (mode bits 3:2) for reads and 0 for writes. In slow mode `xb_adv_n` stays high.
- R9: `req_ready` is low from the cycle after acceptance until the access has finished. At most one select is low at a time, and `xb_addr` equals the request address while it is low.
- R10: A configuration write with `cfg_we`=1 sets a field of chip select `cfg_cs`. The `cfg_field` codes are: 0 read-wait[3:0], 1 write-wait[3:0], 2 write-hold[3:0], 3 recovery[3:0], 4 read-latency[7:0], 5 write-latency[7:0], 6 mode[3:0]. A write with `cfg_cs` of 6 or 7, or with field code 7, changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_cs | input | 3 | Chip select whose timing is written |
| cfg_field | input | 3 | Timing field code |
| cfg_data | input | 8 | Field value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_cs | input | 3 | Target chip select, 0 to 5 |
| req_addr | input | 9 | External word address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| xb_addr | output | 9 | External address |
| xb_dq_o | output | 16 | Data driven to the bus |
| xb_dq_i | input | 16 | Data sampled from the bus |
| xb_dq_oe | output | 1 | Data output enable toward the pads |
| xb_cs_n | output | 6 | Active-low chip selects |
| xb_adv_n | output | 1 | Active-low address valid |
| xb_oe_n | output | 1 | Active-low output enable |
| xb_we_n | output | 1 | Active-low write enable |

## Verification
The hardest case to reach from the ports is an access where recovery and page latency both apply, with the two counts taken from different chip selects. A read on one select, followed by a write on another select whose page latency is nonzero, yields it. The bench builds such chains on purpose: a read on a select with a large recovery field, then a write to a different page, then a read back on the same page. A bench-side model of the last select, the last page and the last direction predicts the idle span of every access, and each access is measured phase by phase (idle, address-valid, setup, strobe, hold).

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // One chip select's timing set; recovery is stored apart (read by a second port)
  typedef struct packed {
    logic [3:0] rd_wait;
    logic [3:0] wr_wait;
    logic [3:0] wr_hold;
    logic [7:0] rd_lat;
    logic [7:0] wr_lat;
    logic       fast;
    logic       ahold;
    logic [1:0] gap;
  } xb_timing_t;

  typedef enum logic [2:0] {
    F_RD_WAIT = 3'd0,
    F_WR_WAIT = 3'd1,
    F_WR_HOLD = 3'd2,
    F_RECOV   = 3'd3,
    F_RD_LAT  = 3'd4,
    F_WR_LAT  = 3'd5,
    F_MODE    = 3'd6
  } xb_field_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RECOV  = 3'd1,
    S_LAT    = 3'd2,
    S_ADV    = 3'd3,
    S_SETUP  = 3'd4,
    S_STROBE = 3'd5,
    S_HOLD   = 3'd6
  } xb_state_e;

endpackage

// File: rtl/xbus_timing_regs.sv
module xbus_timing_regs
  import xbus_pkg::*;
#(
  parameter int NCS   = 6,
  parameter int CSI_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CSI_W-1:0] cfg_cs,
  input  logic [2:0]       cfg_field,
  input  logic [7:0]       cfg_data,
  input  logic [CSI_W-1:0] cur_idx,
  output xb_timing_t       cur_t,
  input  logic [CSI_W-1:0] prev_idx,
  output logic [3:0]       prev_recov
);

  xb_timing_t tim   [NCS];
  logic [3:0] recov [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic hit;
    assign hit = cfg_we && (cfg_cs == CSI_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tim[g]   <= '0;
        recov[g] <= '0;
      end else if (hit) begin
        case (cfg_field)
          F_RD_WAIT: tim[g].rd_wait <= cfg_data[3:0];
          F_WR_WAIT: tim[g].wr_wait <= cfg_data[3:0];
          F_WR_HOLD: tim[g].wr_hold <= cfg_data[3:0];
          F_RECOV:   recov[g]       <= cfg_data[3:0];
          F_RD_LAT:  tim[g].rd_lat  <= cfg_data;
          F_WR_LAT:  tim[g].wr_lat  <= cfg_data;
          F_MODE: begin
            tim[g].fast  <= cfg_data[0];
            tim[g].ahold <= cfg_data[1];
            tim[g].gap   <= cfg_data[3:2];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cur_t      = '0;
    prev_recov = '0;
    for (int i = 0; i < NCS; i++) begin
      if (cur_idx == CSI_W'(i))  cur_t      = tim[i];
      if (prev_idx == CSI_W'(i)) prev_recov = recov[i];
    end
  end

endmodule

// File: rtl/xbus_page_track.sv
module xbus_page_track #(
  parameter int CSI_W  = 3,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [CSI_W-1:0]  req_cs,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_write,
  output logic              page_miss,
  output logic              owe_recov,
  output logic [CSI_W-1:0]  last_cs
);

  logic              have_last;
  logic              last_rd;
  logic [PAGE_W-1:0] last_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_rd   <= 1'b0;
      last_cs   <= '0;
      last_page <= '0;
    end else if (upd) begin
      have_last <= 1'b1;
      last_rd   <= !req_write;
      last_cs   <= req_cs;
      last_page <= req_page;
    end
  end

  assign page_miss = !have_last || (req_cs != last_cs) || (req_page != last_page);
  assign owe_recov = have_last && last_rd && ((req_cs != last_cs) || req_write);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cur_write,
  input  logic              owe_recov,
  input  logic              page_miss,
  input  logic [3:0]        prev_recov,
  input  xb_timing_t        cur_t,
  input  logic [DATA_W-1:0] xb_dq_i,
  output xb_state_e         state,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int CNT_W = 8;

  xb_state_e        nxt_state;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             miss_q;

  logic [3:0]       wait_n;
  logic [7:0]       lat_n;
  logic [3:0]       recov_eff;
  logic [2:0]       setup_n;
  logic             miss_now;
  logic             lat_go;
  xb_state_e        body_st, post_st;
  logic [CNT_W-1:0] body_cnt, post_cnt;
  logic             last_rd_beat;

  always_comb begin
    wait_n    = cur_write ? cur_t.wr_wait : cur_t.rd_wait;
    lat_n     = cur_write ? cur_t.wr_lat  : cur_t.rd_lat;
    recov_eff = (prev_recov == 4'd0) ? 4'd1 : prev_recov;
    setup_n   = {2'b00, cur_t.ahold} + (cur_write ? 3'd0 : {1'b0, cur_t.gap});
    miss_now  = (state == S_IDLE) ? page_miss : miss_q;
    lat_go    = miss_now && (lat_n != 8'd0);
    body_st   = cur_t.fast ? S_ADV : S_STROBE;
    body_cnt  = cur_t.fast ? '0 : {4'b0000, wait_n};
    post_st   = lat_go ? S_LAT : body_st;
    post_cnt  = lat_go ? (lat_n - 8'd1) : body_cnt;
  end

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (owe_recov) begin
            nxt_state = S_RECOV;
            nxt_cnt   = {4'b0000, recov_eff - 4'd1};
          end else begin
            nxt_state = post_st;
            nxt_cnt   = post_cnt;
          end
        end
      end
      S_RECOV: begin
        if (cnt == '0) begin
          nxt_state = post_st;
          nxt_cnt   = post_cnt;
        end else nxt_cnt = cnt - 1'b1;
      end
      S_LAT: begin
        if (cnt == '0) begin
          nxt_state = body_st;
          nxt_cnt   = body_cnt;
        end else nxt_cnt = cnt - 1'b1;
      end
      S_ADV: begin
        if (setup_n != 3'd0) begin
          nxt_state = S_SETUP;
          nxt_cnt   = {5'b00000, setup_n - 3'd1};
        end else begin
          nxt_state = S_STROBE;
          nxt_cnt   = {4'b0000, wait_n};
        end
      end
      S_SETUP: begin
        if (cnt == '0) begin
          nxt_state = S_STROBE;
          nxt_cnt   = {4'b0000, wait_n};
        end else nxt_cnt = cnt - 1'b1;
      end
      S_STROBE: begin
        if (cnt == '0) begin
          nxt_state = cur_write ? S_HOLD : S_IDLE;
          nxt_cnt   = {4'b0000, cur_t.wr_hold};
        end else nxt_cnt = cnt - 1'b1;
      end
      S_HOLD: begin
        if (cnt == '0) nxt_state = S_IDLE;
        else           nxt_cnt   = cnt - 1'b1;
      end
      default: nxt_state = S_IDLE;
    endcase
  end

  assign last_rd_beat = (state == S_STROBE) && (cnt == '0) && !cur_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      miss_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= nxt_state;
      cnt       <= nxt_cnt;
      rsp_valid <= last_rd_beat;
      if (state == S_IDLE && start) miss_q    <= page_miss;
      if (last_rd_beat)             rsp_rdata <= xb_dq_i;
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NCS       = 6,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NCS)-1:0]   cfg_cs,
  input  logic [2:0]               cfg_field,
  input  logic [7:0]               cfg_data,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NCS)-1:0]   req_cs,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        xb_addr,
  output logic [DATA_W-1:0]        xb_dq_o,
  input  logic [DATA_W-1:0]        xb_dq_i,
  output logic                     xb_dq_oe,
  output logic [NCS-1:0]           xb_cs_n,
  output logic                     xb_adv_n,
  output logic                     xb_oe_n,
  output logic                     xb_we_n
);

  localparam int CSI_W  = $clog2(NCS);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  xb_state_e          state;
  logic               idle, accept;
  logic [CSI_W-1:0]   acc_cs, cur_cs, last_cs;
  logic [ADDR_W-1:0]  acc_addr;
  logic               acc_write, cur_write;
  logic [DATA_W-1:0]  acc_wdata;
  xb_timing_t         cur_t;
  logic [3:0]         prev_recov;
  logic               page_miss, owe_recov;
  logic               sel_active;
  logic [NCS-1:0]     cs_onehot;

  assign idle      = (state == S_IDLE);
  assign accept    = idle && req_valid;
  assign req_ready = idle;
  assign cur_cs    = idle ? req_cs    : acc_cs;
  assign cur_write = idle ? req_write : acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cs    <= '0;
      acc_addr  <= '0;
      acc_write <= 1'b0;
      acc_wdata <= '0;
    end else if (accept) begin
      acc_cs    <= req_cs;
      acc_addr  <= req_addr;
      acc_write <= req_write;
      acc_wdata <= req_wdata;
    end
  end

  xbus_timing_regs #(.NCS(NCS), .CSI_W(CSI_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_cs     (cfg_cs),
    .cfg_field  (cfg_field),
    .cfg_data   (cfg_data),
    .cur_idx    (cur_cs),
    .cur_t      (cur_t),
    .prev_idx   (last_cs),
    .prev_recov (prev_recov)
  );

  xbus_page_track #(.CSI_W(CSI_W), .PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (accept),
    .req_cs    (req_cs),
    .req_page  (req_addr[ADDR_W-1:PAGE_BITS]),
    .req_write (req_write),
    .page_miss (page_miss),
    .owe_recov (owe_recov),
    .last_cs   (last_cs)
  );

  xbus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .cur_write  (cur_write),
    .owe_recov  (owe_recov),
    .page_miss  (page_miss),
    .prev_recov (prev_recov),
    .cur_t      (cur_t),
    .xb_dq_i    (xb_dq_i),
    .state      (state),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // Pin decode depends only on state and captured fields, never on request inputs
  assign sel_active = (state == S_ADV) || (state == S_SETUP) ||
                      (state == S_STROBE) || (state == S_HOLD);

  for (genvar g = 0; g < NCS; g++) begin : g_sel
    assign cs_onehot[g] = (acc_cs == CSI_W'(g));
  end

  assign xb_cs_n  = sel_active ? ~cs_onehot : '1;
  assign xb_adv_n = !(state == S_ADV);
  assign xb_oe_n  = !((state == S_STROBE) && !acc_write);
  assign xb_we_n  = !((state == S_STROBE) && acc_write);
  assign xb_dq_oe = acc_write && ((state == S_STROBE) || (state == S_HOLD));
  assign xb_addr  = acc_addr;
  assign xb_dq_o  = acc_wdata;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int NCS    = 6,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] xb_addr,
  input logic              xb_dq_oe,
  input logic [NCS-1:0]    xb_cs_n,
  input logic              xb_adv_n,
  input logic              xb_oe_n,
  input logic              xb_we_n
);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~xb_cs_n)); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xb_oe_n && !xb_we_n)); // R2

  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!xb_oe_n || !xb_we_n) |-> !(&xb_cs_n)); // R2

  AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    xb_dq_oe |-> (xb_oe_n && !(&xb_cs_n))); // R4

  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xb_we_n) |-> (xb_cs_n == $past(xb_cs_n)) && xb_dq_oe); // R5

  AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!xb_oe_n) && xb_oe_n)); // R3

  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&xb_cs_n) && xb_oe_n && xb_we_n && !xb_dq_oe)); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&xb_cs_n) && (xb_cs_n == $past(xb_cs_n))) |-> $stable(xb_addr)); // R9

  AST_ADV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !xb_adv_n |-> (!(&xb_cs_n) && $past(&xb_cs_n) && xb_oe_n && xb_we_n)); // R8

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [2:0]  cfg_field = '0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cs = '0;
  logic [8:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  xb_addr;
  logic [15:0] xb_dq_o;
  logic [15:0] xb_dq_i;
  logic        xb_dq_oe;
  logic [5:0]  xb_cs_n;
  logic        xb_adv_n, xb_oe_n, xb_we_n;

  always #2 clk = ~clk;

  xbus_ctrl u_xbus_ctrl (.*);

  // External device model: drives a pattern from select and address while OE is low
  assign xb_dq_i = !xb_oe_n ? (16'hC3A5 ^ {1'b0, ~xb_cs_n, xb_addr}) : 16'h0000;

  int n_cmp = 0;
  int n_bad = 0;

  // Shadow of programmed timing and of the previous access
  int m_rdw[6], m_wrw[6], m_wh[6], m_rec[6], m_rl[6], m_wl[6], m_mode[6];
  bit have_last = 0;
  int last_cs = 0, last_page = 0;
  bit last_rd = 0;

  task automatic chk(string req, int act, int exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(int cs, int field, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_field = 3'(field); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (cs < 6) begin
      case (field)
        0: m_rdw[cs] = val & 15;
        1: m_wrw[cs] = val & 15;
        2: m_wh[cs]  = val & 15;
        3: m_rec[cs] = val & 15;
        4: m_rl[cs]  = val & 255;
        5: m_wl[cs]  = val & 255;
        6: m_mode[cs] = val & 15;
        default: ;
      endcase
    end
  endtask

  task automatic access(int cs, int addr, bit wr, logic [15:0] wd);
    int exp_pre, exp_adv, exp_setup, exp_strobe, exp_hold, rec, lat;
    int pre = 0, adv = 0, setup = 0, strobe = 0, hold = 0, guard = 0;
    int bad_cs = 0, bad_addr = 0, bad_dq = 0, bad_rdy = 0, bad_rsp = 0, bad_kind = 0;
    bit started = 0, done = 0, fast;
    logic [15:0] exp_rd;
    fast = m_mode[cs][0];
    rec = (have_last && last_rd && (cs != last_cs || wr)) ?
          ((m_rec[last_cs] == 0) ? 1 : m_rec[last_cs]) : 0;
    lat = (!have_last || cs != last_cs || (addr >> 2) != last_page) ?
          (wr ? m_wl[cs] : m_rl[cs]) : 0;
    exp_pre    = rec + lat;
    exp_adv    = fast ? 1 : 0;
    exp_setup  = fast ? (m_mode[cs][1] + (wr ? 0 : (m_mode[cs] >> 2) & 3)) : 0;
    exp_strobe = (wr ? m_wrw[cs] : m_rdw[cs]) + 1;
    exp_hold   = wr ? m_wh[cs] + 1 : 0;
    exp_rd     = 16'hC3A5 ^ {1'b0, 6'(1 << cs), 9'(addr)};

    chk("R9", int'(req_ready), 1, "ready before request");
    req_valid = 1'b1; req_cs = 3'(cs); req_addr = 9'(addr);
    req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 2000) begin
      if (&xb_cs_n) begin
        if (started) done = 1;
        else begin
          pre++;
          if (xb_dq_oe) bad_dq++;
        end
      end else begin
        started = 1;
        if (xb_cs_n != ~6'(1 << cs)) bad_cs++;
        if (xb_addr != 9'(addr)) bad_addr++;
        if (wr && !xb_oe_n) bad_kind++;
        if (!wr && !xb_we_n) bad_kind++;
        if (!xb_adv_n) adv++;
        else if (!xb_oe_n || !xb_we_n) strobe++;
        else if (strobe > 0) hold++;
        else setup++;
        if (xb_dq_oe !== (wr && strobe > 0)) bad_dq++;
        if (xb_dq_oe && xb_dq_o !== wd) bad_dq++;
      end
      if (!done) begin
        if (req_ready) bad_rdy++;
        if (rsp_valid) bad_rsp++;
        @(negedge clk);
        guard++;
      end
    end
    chk("R9", int'(done), 1, "access completed");
    chk("R9", int'(req_ready), 1, "ready after access");
    chk("R9", bad_rdy, 0, "ready low while busy");
    chk("R9", bad_cs, 0, "wrong select pattern");
    chk("R9", bad_addr, 0, "address not held");
    chk("R6 R7", pre, exp_pre, "idle cycles before select");
    chk("R8", adv, exp_adv, "address-valid cycles");
    chk("R8", setup, exp_setup, "setup cycles");
    if (wr) begin
      chk("R4", strobe, exp_strobe, "write strobe cycles");
      chk("R5", hold, exp_hold, "write hold cycles");
      chk("R4", bad_dq, 0, "data drive errors");
      chk("R4", bad_kind, 0, "wrong strobe type");
      chk("R3", int'(rsp_valid), 0, "no response for write");
    end else begin
      chk("R2", strobe, exp_strobe, "read strobe cycles");
      chk("R2", bad_dq + bad_kind, 0, "read drive or strobe errors");
      chk("R3", bad_rsp, 0, "early response");
      chk("R3", int'(rsp_valid), 1, "response after OE");
      chk("R3", int'(rsp_rdata), int'(exp_rd), "read data");
      @(negedge clk);
      chk("R3", int'(rsp_valid), 0, "response one cycle only");
    end
    have_last = 1; last_cs = cs; last_page = addr >> 2; last_rd = !wr;
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    chk("R1", int'(xb_cs_n), 'h3f, "selects in reset");
    chk("R1", int'({xb_adv_n, xb_oe_n, xb_we_n}), 7, "strobes in reset");
    chk("R1", int'(xb_dq_oe), 0, "drive in reset");
    chk("R1", int'(rsp_valid), 0, "response in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(req_ready), 1, "ready after reset");
    chk("R1", int'(xb_cs_n), 'h3f, "selects after reset");
    access(0, 'h010, 0, '0);   // R1 minimum timing: one strobe cycle, no latency
  endtask

  task automatic test_read_wait;
    cfg(1, 0, 5);
    access(1, 'h021, 0, '0);   // R2 six OE cycles, R7 page miss with zero latency
    access(1, 'h022, 0, '0);   // same page, same select: no recovery
  endtask

  task automatic test_write_hold;
    cfg(1, 1, 3);
    cfg(1, 2, 2);
    access(1, 'h022, 1, 16'hBEEF);  // R6 read-to-write recovery of one, R4 R5
    access(1, 'h023, 1, 16'h1234);  // after write: no recovery
    cfg(1, 1, 0);
    cfg(1, 2, 0);
    access(1, 'h023, 1, 16'h00FF);  // minimum write: one strobe, one hold
  endtask

  task automatic test_recovery;
    cfg(2, 3, 4);
    cfg(2, 0, 2);
    access(2, 'h040, 0, '0);
    access(2, 'h041, 0, '0);   // R6 read after read, same select: none
    access(3, 'h041, 0, '0);   // R6 other select: four cycles from select 2
    access(2, 'h040, 0, '0);   // select 3 recovery field is 0: still one cycle
    access(2, 'h040, 1, 16'hA5A5); // R6 write after read same select: four
    access(3, 'h100, 0, '0);   // after write: no recovery
  endtask

  task automatic test_page_latency;
    cfg(4, 4, 7);
    cfg(4, 5, 12);
    cfg(4, 3, 2);
    access(4, 'h020, 0, '0);   // R7 miss: seven
    access(4, 'h023, 0, '0);   // R7 same page: none
    access(4, 'h024, 0, '0);   // R7 next page: seven
    access(4, 'h024, 1, 16'h0F0F); // R6 two recovery, page hit
    access(4, 'h1FC, 1, 16'hF0F0); // R7 write miss: twelve
    access(5, 'h1FC, 0, '0);   // same page bits, other select: miss
    access(4, 'h1FD, 1, 16'h5555); // R6 recovery from select 5 (one) plus R7 write miss
  endtask

  task automatic test_fast_mode;
    cfg(5, 6, 'b1011);          // fast, address hold, gap 2
    cfg(5, 0, 1);
    access(5, 'h0A0, 0, '0);    // R8 one ADV, three setup
    access(5, 'h0A1, 1, 16'h7E7E); // R8 write: one setup
    cfg(5, 6, 'b0001);          // fast, no hold, gap 0
    access(5, 'h0A2, 0, '0);    // R8 no setup
    cfg(5, 6, 'b1101);          // fast, no hold, gap 3
    access(5, 'h0A3, 0, '0);
    cfg(5, 6, 0);
    access(5, 'h0A3, 0, '0);    // R8 slow: ADV stays high
  endtask

  task automatic test_cfg_ignore;
    cfg(2, 0, 3);
    cfg(6, 0, 15);              // R10 select index 6 does not exist
    cfg(7, 2, 9);               // R10 select index 7 does not exist
    cfg(6, 4, 200);
    cfg(2, 7, 15);              // R10 field code 7 does nothing
    access(2, 'h0C0, 0, '0);
    access(2, 'h0C0, 1, 16'h3C3C);
    access(3, 'h0C4, 0, '0);
    access(0, 'h0C8, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_rdw[i] = 0; m_wrw[i] = 0; m_wh[i] = 0; m_rec[i] = 0;
      m_rl[i] = 0; m_wl[i] = 0; m_mode[i] = 0;
    end
    test_reset();
    test_read_wait();
    test_write_hold();
    test_recovery();
    test_page_latency();
    test_fast_mode();
    test_cfg_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule